// File: doc/BRIEF.md
# SPI EEPROM Status Register and Write-Protection Control

This block keeps the status byte of a serial EEPROM and decides, cycle by cycle, whether a status-write or an array-write command may start. A command engine sends it single-cycle requests: set the write-enable latch, clear the latch, start a status write with its data byte, start an array write, and signal that the self-timed cycle has finished. The block replies with the status byte, the write-enable latch, the busy flag, a permit for status writes and a flag that says whether the address presented on `chk_addr` falls inside the block-protected region.

Two protection mechanisms are combined. In software protection, two protect bits select no region, the upper quarter, the upper half or the whole array. In hardware-protected mode, a non-volatile lock bit together with a low level on the active-low write-protect pin freezes the status bits, and the two conditions can occur in either order. New lock and protect values are held in a shadow register and take effect only when the timed status write completes. The command engine asserts `sr_wr_req` only for a data byte that chip select properly terminated, meaning chip select rose after the eighth data bit and before the next rising clock edge. Decoding the serial stream and storing the array data are done outside this block.

Top module: `eep_status_ctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the status byte is 00h, so the lock bit, both protect bits, the latch and the busy flag are all 0.
- R2: The status byte carries the lock bit in bit 7, the upper protect bit in bit 3, the lower protect bit in bit 2, the latch in bit 1 and the busy flag in bit 0. Bits 6 to 4 always read 0.
- R3: While not busy, `wel_set_req` sets the latch and `wel_clr_req` clears it at the next edge. While busy, both requests have no effect.
- R4: A status write is accepted only when the latch is 1, the block is not busy and hardware-protected mode is off. An accepted write makes the busy flag 1 at the next edge. A rejected write changes no state.
- R5: During an accepted status write the old lock and protect bits stay in force, including for `page_prot`. The completion pulse loads bits 7, 3 and 2 of the data byte into the lock, upper protect and lower protect bits. It also clears both the busy flag and the latch. All other data bits are ignored.
- R6: Hardware-protected mode holds exactly when the lock bit is 1 and `wp_n` is low. It is entered whichever of the two conditions happens first and is left only by driving `wp_n` high. `sr_wr_permit` equals latch AND NOT busy AND NOT protected-mode, and it is combinational in `wp_n`.
- R7: `page_prot` is combinational. The protect code 00 protects nothing, 01 protects the upper quarter, 10 the upper half and 11 everything. For the default 2048-byte array these ranges are 600h–7FFh, 400h–7FFh and 000h–7FFh.
- R8: An array write is accepted only when the latch is 1, the block is not busy and `page_prot` is 0 for `chk_addr`. Its completion clears the busy flag and the latch and leaves the lock and protect bits unchanged.
- R9: A completion pulse while not busy has no effect.
- R10: When several requests arrive together while not busy, the order of precedence is status write, then array write, then latch clear, then latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low means protect |
| wel_set_req | input | 1 | Write-enable command decoded |
| wel_clr_req | input | 1 | Write-disable command decoded |
| sr_wr_req | input | 1 | Status write command with a valid data byte |
| sr_wr_data | input | 8 | Data byte of the status write |
| arr_wr_req | input | 1 | Array write command ready to start |
| cyc_done | input | 1 | Self-timed cycle finished |
| chk_addr | input | ADDR_W (11) | Byte address checked against the protected region |
| status_byte | output | 8 | Status byte as read by software |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write cycle in progress |
| sr_wr_permit | output | 1 | A status write would be accepted now |
| page_prot | output | 1 | chk_addr lies in the protected region |

## Verification
The hardest state to reach is hardware-protected mode entered pin-first. `wp_n` must already be low while a status write that sets the lock bit is accepted and completes. The protected mode must then be seen to block the next status write, even though the latch was set again. Directed sequences drive both entry orders and the exit through `wp_n`. A seeded random walk then toggles `wp_n` between commands and issues completion pulses at random times, so the bench also meets rejected writes in the middle of a cycle and latch requests that arrive while the block is busy.

// File: rtl/eep_sr_pkg.sv
// Package: shared types and bit positions of the EEPROM status byte.
// Assumes an 8-bit status byte with fixed field positions.
package eep_sr_pkg;

    localparam int SR_LOCK_BIT = 7;
    localparam int SR_BP1_BIT  = 3;
    localparam int SR_BP0_BIT  = 2;
    localparam int SR_WEL_BIT  = 1;
    localparam int SR_WIP_BIT  = 0;

    // Kind of self-timed cycle currently running
    typedef enum logic {
        CYC_ARRAY  = 1'b0,
        CYC_STATUS = 1'b1
    } cyc_kind_e;

    // Non-volatile status fields
    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
    } nv_bits_t;

    // Pick the non-volatile fields out of a status data byte
    function automatic nv_bits_t nv_from_byte(input logic [7:0] b);
        nv_bits_t n;
        n.lock = b[SR_LOCK_BIT];
        n.bp   = {b[SR_BP1_BIT], b[SR_BP0_BIT]};
        return n;
    endfunction

    // Assemble the readable status byte
    function automatic logic [7:0] pack_status(input nv_bits_t n, input logic wel_b,
                                               input logic wip_b);
        logic [7:0] s;
        s              = 8'h00;
        s[SR_LOCK_BIT] = n.lock;
        s[SR_BP1_BIT]  = n.bp[1];
        s[SR_BP0_BIT]  = n.bp[0];
        s[SR_WEL_BIT]  = wel_b;
        s[SR_WIP_BIT]  = wip_b;
        return s;
    endfunction

endpackage

// File: rtl/eep_sr_blockprot.sv
// Module: block-protection decoder.
// Says whether a byte address lies inside the region selected by the two
// protect bits. Assumes ADDR_W >= 2 so that quarter boundaries exist.
module eep_sr_blockprot #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);

    // Compare the address with the base of the selected protected region
    always_comb begin
        unique case (bp)
            2'b00:   prot = 1'b0;
            2'b01:   prot = (addr >= QUARTER_BASE);
            2'b10:   prot = (addr >= HALF_BASE);
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/eep_sr_hwlock.sv
// Module: hardware-protected-mode and status-write permit.
// Protected mode is the AND of the stored lock bit and a low write-protect
// pin, so it is entered in either order. Assumes wp_n is already synchronous.
module eep_sr_hwlock (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic wp_n,
    input  logic wel,
    input  logic wip,
    output logic hpm,
    output logic permit
);
    // Combine the lock bit with the pin, then gate with latch and busy
    always_comb begin
        hpm    = lock & ~wp_n;
        permit = wel & ~wip & ~hpm;
    end

    // R6: a set lock bit with the pin low must always block status writes
    a_r6_hpm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !wp_n) |-> !permit);

    // R4: no status write is permitted during a running cycle
    a_r4_no_permit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !permit);
endmodule

// File: rtl/eep_sr_regs.sv
// Module: status register state.
// Holds the lock and protect bits, the write-enable latch, the busy flag and
// the pending status value. Requests are single-cycle pulses from a command
// engine; while not busy, status write beats array write beats clear beats set.
module eep_sr_regs
    import eep_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set_req,
    input  logic       wel_clr_req,
    input  logic       sr_wr_req,
    input  logic [7:0] sr_wr_data,
    input  logic       arr_wr_req,
    input  logic       cyc_done,
    input  logic       sr_permit,
    input  logic       addr_prot,
    output nv_bits_t   nv_q,
    output logic       wel_q,
    output logic       wip_q
);
    nv_bits_t  pend_q;
    cyc_kind_e kind_q;

    // Register update: completion while busy, command acceptance while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q   <= '0;
            pend_q <= '0;
            wel_q  <= 1'b0;
            wip_q  <= 1'b0;
            kind_q <= CYC_ARRAY;
        end else if (wip_q) begin
            if (cyc_done) begin
                wip_q <= 1'b0;
                wel_q <= 1'b0;
                if (kind_q == CYC_STATUS) begin
                    nv_q <= pend_q;
                end
            end
        end else if (sr_wr_req) begin
            if (sr_permit) begin
                pend_q <= nv_from_byte(sr_wr_data);
                kind_q <= CYC_STATUS;
                wip_q  <= 1'b1;
            end
        end else if (arr_wr_req) begin
            if (wel_q && !addr_prot) begin
                kind_q <= CYC_ARRAY;
                wip_q  <= 1'b1;
            end
        end else if (wel_clr_req) begin
            wel_q <= 1'b0;
        end else if (wel_set_req) begin
            wel_q <= 1'b1;
        end
    end

    // R3: the latch only rises after a set request
    a_r3_wel_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(wel_set_req));

    // R3: latch requests while busy leave the latch alone unless the cycle ends
    a_r3_busy_wel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wip_q && !cyc_done) |=> $stable(wel_q));

    // R4: busy only starts from a write request
    a_r4_wip_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_q) |-> $past(sr_wr_req || arr_wr_req));

    // R5: stored protection changes only at a completion pulse of a busy cycle
    a_r5_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nv_q) |-> $past(wip_q && cyc_done));

    // R5: every completed cycle leaves the latch cleared
    a_r5_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_q) |-> !wel_q);

    // R9: a completion pulse while idle and with no write request changes nothing stored
    a_r9_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!wip_q && cyc_done && !sr_wr_req && !arr_wr_req) |=> ($stable(nv_q) && !wip_q));
endmodule

// File: rtl/eep_status_ctl.sv
// Module: top of the status register and write-protection control.
// Connects the state registers, the hardware-lock logic and the block
// protection decoder. Assumes all inputs are synchronous to clk.
module eep_status_ctl
    import eep_sr_pkg::*;
#(
    parameter  int MEM_BYTES = 2048,
    localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              wel_set_req,
    input  logic              wel_clr_req,
    input  logic              sr_wr_req,
    input  logic [7:0]        sr_wr_data,
    input  logic              arr_wr_req,
    input  logic              cyc_done,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              wel,
    output logic              wip,
    output logic              sr_wr_permit,
    output logic              page_prot
);
    nv_bits_t nv;
    logic     hpm;
    logic     data_unused;

    // Only bits 7, 3 and 2 of a status data byte are meaningful
    assign data_unused = ^{sr_wr_data[6:4], sr_wr_data[1:0], hpm};

    eep_sr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wel_set_req (wel_set_req),
        .wel_clr_req (wel_clr_req),
        .sr_wr_req   (sr_wr_req),
        .sr_wr_data  (sr_wr_data),
        .arr_wr_req  (arr_wr_req),
        .cyc_done    (cyc_done),
        .sr_permit   (sr_wr_permit),
        .addr_prot   (page_prot),
        .nv_q        (nv),
        .wel_q       (wel),
        .wip_q       (wip)
    );

    eep_sr_hwlock u_hwlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (nv.lock),
        .wp_n   (wp_n),
        .wel    (wel),
        .wip    (wip),
        .hpm    (hpm),
        .permit (sr_wr_permit)
    );

    eep_sr_blockprot #(.ADDR_W(ADDR_W)) u_blockprot (
        .bp   (nv.bp),
        .addr (chk_addr),
        .prot (page_prot)
    );

    // Status byte assembly for reads
    always_comb begin
        status_byte = pack_status(nv, wel, wip);
    end

    // R2: reserved status bits always read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6:4] == 3'b000);

    // R7: the topmost byte is protected whenever any protect bit is set
    a_r7_top_protected: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_byte[3:2] != 2'b00) && (chk_addr == '1)) |-> page_prot);

    // R7: with both protect bits clear no address is protected
    a_r7_none_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b00) |-> !page_prot);
endmodule

// File: tb/eep_status_ctl_bench.sv
`timescale 1ns/1ps
module eep_status_ctl_bench;
    localparam int MEM_BYTES = 2048;
    localparam int ADDR_W    = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wp_n = 1'b1;
    logic              wel_set_req = 1'b0;
    logic              wel_clr_req = 1'b0;
    logic              sr_wr_req = 1'b0;
    logic [7:0]        sr_wr_data = 8'h00;
    logic              arr_wr_req = 1'b0;
    logic              cyc_done = 1'b0;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic [7:0]        status_byte;
    logic              wel, wip, sr_wr_permit, page_prot;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic       m_lock, m_wel, m_wip, m_kind_st;
    logic [1:0] m_bp;
    logic       p_lock;
    logic [1:0] p_bp;

    always #2 clk = ~clk;

    eep_status_ctl #(.MEM_BYTES(MEM_BYTES)) u_eep_status_ctl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set_req(wel_set_req),
        .wel_clr_req(wel_clr_req), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
        .arr_wr_req(arr_wr_req), .cyc_done(cyc_done), .chk_addr(chk_addr),
        .status_byte(status_byte), .wel(wel), .wip(wip),
        .sr_wr_permit(sr_wr_permit), .page_prot(page_prot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R7 range rule for a 2^ADDR_W byte array
    function automatic logic exp_prot(input logic [1:0] bp, input logic [ADDR_W-1:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1:ADDR_W-2] == 2'b11;
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    // R2 layout
    function automatic logic [7:0] exp_status();
        return {m_lock, 3'b000, m_bp, m_wel, m_wip};
    endfunction

    function automatic logic exp_permit(input logic pin);
        return m_wel && !m_wip && !(m_lock && !pin);
    endfunction

    localparam int OP_SET = 0, OP_CLR = 1, OP_SRW = 2, OP_ARW = 3, OP_DONE = 4, OP_IDLE = 5;

    // One request cycle: drive, check combinational outputs, clock, update model, check state
    task automatic do_op(input int op, input logic [7:0] d, input logic [ADDR_W-1:0] a,
                         input logic pin);
        logic pr;
        @(negedge clk);
        wp_n = pin; chk_addr = a; sr_wr_data = d;
        wel_set_req = (op == OP_SET); wel_clr_req = (op == OP_CLR);
        sr_wr_req = (op == OP_SRW); arr_wr_req = (op == OP_ARW); cyc_done = (op == OP_DONE);
        #1;
        pr = exp_prot(m_bp, a);
        check("R6 permit", 32'(sr_wr_permit), 32'(exp_permit(pin)));
        check("R7 page_prot", 32'(page_prot), 32'(pr));
        @(posedge clk);
        if (m_wip) begin
            if (op == OP_DONE) begin
                m_wip = 0; m_wel = 0;
                if (m_kind_st) begin m_lock = p_lock; m_bp = p_bp; end
            end
        end else if (op == OP_SRW) begin
            if (exp_permit(pin)) begin
                p_lock = d[7]; p_bp = d[3:2]; m_kind_st = 1; m_wip = 1;
            end
        end else if (op == OP_ARW) begin
            if (m_wel && !pr) begin m_kind_st = 0; m_wip = 1; end
        end else if (op == OP_CLR) m_wel = 0;
        else if (op == OP_SET) m_wel = 1;
        #1;
        wel_set_req = 0; wel_clr_req = 0; sr_wr_req = 0; arr_wr_req = 0; cyc_done = 0;
        check("R2 status_byte", 32'(status_byte), 32'(exp_status()));
        check("R3 wel", 32'(wel), 32'(m_wel));
        check("R4 wip", 32'(wip), 32'(m_wip));
    endtask

    // Full status write sequence: latch set, write, completion
    task automatic write_status(input logic [7:0] d, input logic pin);
        do_op(OP_SET, 8'h00, '0, pin);
        do_op(OP_SRW, d, '0, pin);
        do_op(OP_DONE, 8'h00, '0, pin);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int r;
        m_lock = 0; m_bp = 0; m_wel = 0; m_wip = 0; m_kind_st = 0; p_lock = 0; p_bp = 0;
        r = $urandom(32'd1357);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        #1;
        check("R1 reset status", 32'(status_byte), 32'h00);
        check("R1 reset permit", 32'(sr_wr_permit), 32'h0);

        // R5: old values stay in force during the cycle; reserved data bits ignored
        do_op(OP_SET, 8'h00, '0, 1'b1);
        do_op(OP_SRW, 8'hFF, 11'h7FF, 1'b1);
        check("R5 old bp during cycle", 32'(page_prot), 32'h0);
        check("R5 busy status", 32'(status_byte), 32'h03);
        do_op(OP_SET, 8'h00, '0, 1'b1); // R3: ignored while busy
        do_op(OP_CLR, 8'h00, '0, 1'b1); // R3: ignored while busy
        check("R3 wel kept while busy", 32'(wel), 32'h1);
        do_op(OP_DONE, 8'h00, '0, 1'b1);
        check("R5 applied at completion", 32'(status_byte), 32'h8C);

        // R6: lock set first, then pin low blocks the status write
        do_op(OP_SET, 8'h00, '0, 1'b0);
        check("R6 hpm permit low", 32'(sr_wr_permit), 32'h0);
        do_op(OP_SRW, 8'h00, '0, 1'b0);
        check("R6 rejected write keeps idle", 32'(wip), 32'h0);
        check("R4 rejected write keeps state", 32'(status_byte), 32'h8E);
        // R6: pin high leaves protected mode
        @(negedge clk); wp_n = 1'b1; #1;
        check("R6 pin high permits", 32'(sr_wr_permit), 32'h1);
        do_op(OP_SRW, 8'h00, '0, 1'b1);
        do_op(OP_DONE, 8'h00, '0, 1'b1);
        // R6: pin low first, then lock set
        write_status(8'h80, 1'b0);
        check("R6 lock set with pin low", 32'(status_byte), 32'h80);
        do_op(OP_SET, 8'h00, '0, 1'b0);
        check("R6 hpm pin-first", 32'(sr_wr_permit), 32'h0);
        write_status(8'h00, 1'b1);

        // R7 boundaries for each protect code
        write_status(8'h04, 1'b1);
        do_op(OP_IDLE, 8'h00, 11'h5FF, 1'b1);
        check("R7 quarter below", 32'(page_prot), 32'h0);
        do_op(OP_IDLE, 8'h00, 11'h600, 1'b1);
        check("R7 quarter base", 32'(page_prot), 32'h1);
        write_status(8'h08, 1'b1);
        do_op(OP_IDLE, 8'h00, 11'h3FF, 1'b1);
        check("R7 half below", 32'(page_prot), 32'h0);
        do_op(OP_IDLE, 8'h00, 11'h400, 1'b1);
        check("R7 half base", 32'(page_prot), 32'h1);

        // R8: protected array write rejected, unprotected one accepted
        do_op(OP_SET, 8'h00, '0, 1'b1);
        do_op(OP_ARW, 8'h00, 11'h420, 1'b1);
        check("R8 protected write rejected", 32'(wip), 32'h0);
        do_op(OP_ARW, 8'h00, 11'h020, 1'b1);
        check("R8 unprotected write accepted", 32'(wip), 32'h1);
        do_op(OP_DONE, 8'h00, '0, 1'b1);
        check("R8 completion keeps bp", 32'(status_byte), 32'h08);

        // R9: completion while idle does nothing
        do_op(OP_SET, 8'h00, '0, 1'b1);
        do_op(OP_DONE, 8'h00, '0, 1'b1);
        check("R9 idle done", 32'(status_byte), 32'h0A);

        // R10: simultaneous set and clear while idle, clear wins
        @(negedge clk); wel_set_req = 1; wel_clr_req = 1;
        @(posedge clk); #1; wel_set_req = 0; wel_clr_req = 0; m_wel = 0;
        check("R10 clear beats set", 32'(wel), 32'h0);

        // Seeded random walk
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic pin;
            op  = int'($urandom_range(0, 5));
            if (m_wip && $urandom_range(0, 2) == 0) op = OP_DONE;
            pin = ($urandom_range(0, 3) != 0);
            do_op(op, 8'($urandom), ADDR_W'($urandom), pin);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule